// File: doc/BRIEF.md
# Read-Sequence Write-Protect Unlock Detector

This block holds the software write-protect state of a memory device. It watches the stream of read cycles the host makes. When a fixed seven-read address pattern arrives in order, the block changes a protect flag. The flag gates write commands in the command logic around it. While the flag is high, program and erase commands must be refused.

Each read reaches the block as a single-cycle event, `rd_evt`. The event stands for the first of the two enable lines to rise at the end of the access. The address sampled at that moment comes with it on `rd_addr`. The two patterns share their first six addresses: 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h. Only the seventh address chooses the result. A seventh address of 041Ah unlocks, and a seventh address of 040Ah locks. A write cycle (`wr_evt`) arriving in the middle of a pattern throws away the partial match. The data bus does not enter the block at all, so its contents can never affect detection.

Top module: `wp_unlock_seq_detector`

## Requirements
- R1: After reset is released, `wp_flag` is 1 (protected). An assertion of `rst_n` at any later time also returns it to 1.
- R2: Seven consecutive read events at 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h, 041Ah clear `wp_flag` to 0.
- R3: Seven consecutive read events at 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h, 040Ah set `wp_flag` to 1.
- R4: Only addresses presented with `rd_evt`=1 take part in matching. Cycles with `rd_evt`=0 neither advance nor break a pattern, and they do not change `wp_flag`, whatever `rd_addr` holds.
- R5: A read event whose address is not the next expected entry restarts matching. The remaining entries of the interrupted pattern then have no effect on `wp_flag`.
- R6: A mismatching read event at 1823h counts as the first entry of a new pattern.
- R7: A write event (`wr_evt`=1) drops any partial match, and the next pattern has to start again from 1823h. When `wr_evt` and `rd_evt` occur in the same cycle, the write wins and the read is not counted.
- R8: A write event never changes `wp_flag`. This includes a reset command written while the flag is 0.
- R9: A seventh read whose address is neither 041Ah nor 040Ah leaves `wp_flag` unchanged and restarts matching.
- R10: `wp_flag` takes its new value on the clock edge that samples the seventh read event. Repeating a pattern that matches the current state leaves the flag as it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset; its release is synchronized inside |
| rd_evt | input | 1 | One-cycle pulse marking the end of a read access |
| rd_addr | input | 16 | Address sampled with the read event |
| wr_evt | input | 1 | One-cycle pulse marking a write cycle |
| wp_flag | output | 1 | 1 = writes are protected, 0 = writes are allowed |

## Verification
The assertions check four things on every cycle. The flag holds on any cycle without a counted read (R4, R8). A write always empties the step counter (R7). The flag falls only after a counted 041Ah read, and it rises only after a counted 040Ah read or a reset (R2, R3). The assertions cannot show that the flag actually changes after a complete pattern, that partial or broken patterns fail, or that a mismatching 1823h starts a new attempt. Those outcomes depend on the full history of reads, so the directed scenarios cover them: full unlock and lock, broken patterns, restart on 1823h, an aborting write, a wrong seventh address, idle gaps and a mid-run reset.

// File: rtl/wpseq_pkg.sv
package wpseq_pkg;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned PREFIX_LEN = 6;
  localparam int unsigned STEP_W     = $clog2(PREFIX_LEN + 1);

  localparam logic [ADDR_W-1:0] TERM_UNLOCK = 16'h041A;
  localparam logic [ADDR_W-1:0] TERM_LOCK   = 16'h040A;

  // Shared leading addresses of both patterns, in required order.
  function automatic logic [ADDR_W-1:0] prefix_addr(input int unsigned idx);
    case (idx)
      0:       prefix_addr = 16'h1823;
      1:       prefix_addr = 16'h1820;
      2:       prefix_addr = 16'h1822;
      3:       prefix_addr = 16'h0418;
      4:       prefix_addr = 16'h041B;
      default: prefix_addr = 16'h0419;
    endcase
  endfunction
endpackage

// File: rtl/wpseq_rst_sync.sv
module wpseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wpseq_step_tracker.sv
module wpseq_step_tracker
  import wpseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [STEP_W-1:0] step,
  output logic              hit_unlock,
  output logic              hit_lock
);
  logic [PREFIX_LEN-1:0] pre_hit;
  logic                  exp_hit;
  logic                  rd_ok;
  logic                  at_last;
  logic [STEP_W-1:0]     step_d, step_q;

  for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_cmp
    assign pre_hit[i] = (rd_addr == prefix_addr(i));
  end

  assign rd_ok   = rd_evt && !wr_evt;
  assign at_last = (step_q == STEP_W'(PREFIX_LEN));

  always_comb begin
    exp_hit = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (step_q == STEP_W'(i)) exp_hit = pre_hit[i];
    end
  end

  always_comb begin
    step_d = step_q;
    if (wr_evt) begin
      step_d = '0;
    end else if (rd_evt) begin
      if (!at_last && exp_hit) step_d = step_q + STEP_W'(1);
      else if (pre_hit[0])     step_d = STEP_W'(1);
      else                     step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign step       = step_q;
  assign hit_unlock = rd_ok && at_last && (rd_addr == TERM_UNLOCK);
  assign hit_lock   = rd_ok && at_last && (rd_addr == TERM_LOCK);
endmodule

// File: rtl/wpseq_flag.sv
module wpseq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  logic flag_d, flag_q, flag_en;

  assign flag_en = set_evt || clr_evt;

  always_comb begin
    flag_d = flag_q;
    if (set_evt)      flag_d = 1'b1;
    else if (clr_evt) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b1;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/wp_unlock_seq_detector.sv
module wp_unlock_seq_detector
  import wpseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_evt,
  output logic              wp_flag
);
  logic              rst_sync_n;
  logic [STEP_W-1:0] step;
  logic              hit_unlock, hit_lock;

  wpseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wpseq_step_tracker u_track (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_evt     (rd_evt),
    .wr_evt     (wr_evt),
    .rd_addr    (rd_addr),
    .step       (step),
    .hit_unlock (hit_unlock),
    .hit_lock   (hit_lock)
  );

  wpseq_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_evt (hit_lock),
    .clr_evt (hit_unlock),
    .flag    (wp_flag)
  );
endmodule

// File: rtl/wp_unlock_seq_detector_chk.sv
module wp_unlock_seq_detector_chk
  import wpseq_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              rd_evt,
  input logic              wr_evt,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [STEP_W-1:0] step,
  input logic              wp_flag
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_evt |=> $stable(wp_flag)); // R4

  AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_evt |=> $stable(wp_flag)); // R8

  AST_WRITE_DROPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_evt |=> (step == '0)); // R7

  AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(wp_flag) |-> $past(rd_evt && !wr_evt && rd_addr == TERM_UNLOCK)); // R2

  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(wp_flag) |-> $past(rd_evt && !wr_evt && rd_addr == TERM_LOCK)); // R3

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step <= STEP_W'(PREFIX_LEN)); // R5
endmodule

bind wp_unlock_seq_detector wp_unlock_seq_detector_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .rd_evt     (rd_evt),
  .wr_evt     (wr_evt),
  .rd_addr    (rd_addr),
  .step       (step),
  .wp_flag    (wp_flag)
);

// File: tb/wp_unlock_seq_detector_test.sv
module wp_unlock_seq_detector_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_evt;
  logic [15:0] rd_addr;
  logic        wr_evt;
  logic        wp_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  wp_unlock_seq_detector uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_evt  (rd_evt),
    .rd_addr (rd_addr),
    .wr_evt  (wr_evt),
    .wp_flag (wp_flag)
  );

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (wp_flag !== exp) begin
      n_fail++;
      $display("FAIL %s: wp_flag=%b expected=%b", req, wp_flag, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk); rd_evt = 1'b1; rd_addr = a;
    @(negedge clk); rd_evt = 1'b0; rd_addr = 16'h0000;
  endtask

  task automatic wr();
    @(negedge clk); wr_evt = 1'b1;
    @(negedge clk); wr_evt = 1'b0;
  endtask

  task automatic prefix();
    rd(16'h1823); rd(16'h1820); rd(16'h1822);
    rd(16'h0418); rd(16'h041B); rd(16'h0419);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset", 1'b1);
  endtask

  task automatic t_unlock();
    prefix();
    check("R10 no change before seventh", 1'b1);
    rd(16'h041A);
    check("R2 unlock", 1'b0);
    prefix(); rd(16'h041A);
    check("R10 repeat unlock", 1'b0);
  endtask

  task automatic t_lock();
    prefix(); rd(16'h040A);
    check("R3 lock", 1'b1);
    prefix(); rd(16'h040A);
    check("R10 repeat lock", 1'b1);
  endtask

  task automatic t_mismatch();
    rd(16'h1823); rd(16'h1820); rd(16'h5555);
    rd(16'h1822); rd(16'h0418); rd(16'h041B); rd(16'h0419); rd(16'h041A);
    check("R5 broken pattern", 1'b1);
  endtask

  task automatic t_restart_1823();
    rd(16'h1823); rd(16'h1820); rd(16'h1823);
    rd(16'h1820); rd(16'h1822); rd(16'h0418); rd(16'h041B); rd(16'h0419);
    rd(16'h041A);
    check("R6 1823 restart", 1'b0);
  endtask

  task automatic t_idle_gaps();
    rd(16'h1823);
    @(negedge clk); rd_addr = 16'hFFFF;
    @(negedge clk); rd_addr = 16'h0000;
    rd(16'h1820); rd(16'h1822);
    repeat (5) @(negedge clk);
    rd(16'h0418); rd(16'h041B); rd(16'h0419);
    @(negedge clk); rd_addr = 16'h040A;
    @(negedge clk); rd_addr = 16'h0000;
    check("R4 idle address ignored", 1'b0);
    rd(16'h040A);
    check("R4 pattern spans idle cycles", 1'b1);
  endtask

  task automatic t_write_abort();
    prefix(); rd(16'h041A);
    check("R2 unlock before write", 1'b0);
    wr();
    check("R8 reset command keeps unlocked", 1'b0);
    rd(16'h1823); rd(16'h1820); rd(16'h1822);
    wr();
    rd(16'h0418); rd(16'h041B); rd(16'h0419); rd(16'h040A);
    check("R7 write aborts", 1'b0);
    rd(16'h1823); rd(16'h1820); rd(16'h1822); rd(16'h0418); rd(16'h041B);
    @(negedge clk); rd_evt = 1'b1; wr_evt = 1'b1; rd_addr = 16'h0419;
    @(negedge clk); rd_evt = 1'b0; wr_evt = 1'b0; rd_addr = 16'h0000;
    rd(16'h040A);
    check("R7 write wins over read", 1'b0);
  endtask

  task automatic t_bad_seventh();
    prefix(); rd(16'h041B);
    check("R9 wrong seventh", 1'b0);
    rd(16'h040A);
    check("R9 restart after seventh", 1'b0);
    prefix(); rd(16'h040A);
    check("R3 lock after wrong seventh", 1'b1);
  endtask

  task automatic t_midrun_reset();
    prefix(); rd(16'h041A);
    check("R2 unlock before reset", 1'b0);
    rd(16'h1823); rd(16'h1820);
    do_reset();
    check("R1 reset re-protects", 1'b1);
    rd(16'h1822); rd(16'h0418); rd(16'h041B); rd(16'h0419); rd(16'h041A);
    check("R1 reset clears partial", 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; rd_evt = 1'b0; wr_evt = 1'b0; rd_addr = 16'h0000;
    t_reset();
    t_unlock();
    t_lock();
    t_mismatch();
    t_restart_1823();
    t_idle_gaps();
    t_write_abort();
    t_bad_seventh();
    t_midrun_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule